// File: doc/BRIEF.md
# Auto-Reload Timebase Counter

This block is a small periodic timebase. An up-counter advances once for each cycle in which a prescaled tick strobe is high. When the count passes its all-ones value, the counter does not restart at zero. It takes a start value that software has programmed into a reload register. Each wrap sets an event flag. When software has enabled the interrupt, the flag drives an interrupt request line.

Software reaches the block through three word addresses. The status/control word holds the interrupt enable and the event flag. The reload word can be read and written. The live count can be read but not written. Reading the status word is what acknowledges an event: the read clears the flag as a side effect. A processor-level halt input stops the counter entirely, and all other reduced-power states leave it running. Software sets the wrap period by choosing how far below the top of the range the reload value lies.

Top module: `tbase_reload_timer`

## Requirements
- R1: After reset the status word, the reload word and the count all read 0x00, and irqReq is 0.
- R2: The count increases by one at each clock edge where tickEn is 1 and haltMode is 0. At any other edge it holds its value.
- R3: While haltMode is 1 the count and the event flag do not change, whatever tickEn does.
- R4: At an enabled tick with the count at 0xFF, the count takes the reload value and the event flag (status bit 0) is set.
- R5: Address 1 is the reload word and can be read and written. Writing it leaves the running count unchanged, and the new value is first used at the next wrap.
- R6: A read of address 0 returns the flag as it was before the read and then clears it. Writing bit 0 of address 0 has no effect.
- R7: If a wrap and a read of address 0 occur in the same cycle, the read returns the old flag and the flag ends up set.
- R8: Status bit 1 is the interrupt enable, which software reads and writes. Status bits 7:2 always read 0, and writes to them are ignored.
- R9: irqReq is a registered level that equals the AND of the enable and the flag as they stood one cycle earlier.
- R10: Address 2 returns the live count and ignores writes. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Prescaled count strobe, one cycle wide |
| haltMode | input | 1 | Full-halt indication; freezes the counter |
| regSel | input | 2 | Register address: 0 status, 1 reload, 2 count, 3 unused |
| regWr | input | 1 | Write strobe for the selected register |
| regRd | input | 1 | Read strobe; a read of address 0 clears the flag |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register (combinational) |
| irqReq | output | 1 | Interrupt request level |

## Verification
The bench targets the wrap edge in both directions. It runs the counter exactly up to 0xFF to confirm that no early event appears. It then ticks once more to confirm the reload and the flag. A design that wrapped to zero, or that raised the event one tick early or late, would return the wrong count. The bench also collides a status read with a wrap in the same cycle, and a design that let the clear win would lose that event. It writes the reload word in the middle of a period and with the value 0xFF. A design that loaded the counter on write, or that failed to wrap every tick at 0xFF, would show the wrong count. Finally it ticks under halt and writes to the flag and reserved bits, which a careless design would let through.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic reloadWr;
  } dpStrobe_t;
endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             haltMode,
  input  logic [SEL_W-1:0] regSel,
  input  logic             regWr,
  input  logic             regRd,
  input  logic             ieWrBit,
  input  logic             ovfPulse,
  output dpStrobe_t        strobe,
  output logic             ieQ,
  output logic             flagQ,
  output logic             irqReq
);
  regSel_e selCode;
  logic    statRead;
  logic    statWrite;

  always_comb begin
    selCode         = regSel_e'(regSel);
    statRead        = regRd && (selCode == SEL_STAT);
    statWrite       = regWr && (selCode == SEL_STAT);
    strobe.advance  = tickEn && !haltMode;
    strobe.reloadWr = regWr && (selCode == SEL_RELOAD);
  end

  // enable: software owned
  always_ff @(posedge clk) begin
    if (!rst_n)         ieQ <= 1'b0;
    else if (statWrite) ieQ <= ieWrBit;
  end

  // flag: a new event wins over a read-clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        flagQ <= 1'b0;
    else if (ovfPulse) flagQ <= 1'b1;
    else if (statRead) flagQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irqReq <= 1'b0;
    else        irqReq <= ieQ && flagQ;
  end
endmodule

// File: rtl/tbase_datapath.sv
module tbase_datapath
  import tbase_pkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] reloadQ,
  output logic             ovfPulse
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  assign ovfPulse = strobe.advance && (countVal == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)               reloadQ <= '0;
    else if (strobe.reloadWr) reloadQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              countVal <= '0;
    else if (ovfPulse)       countVal <= reloadQ;
    else if (strobe.advance) countVal <= countVal + 1'b1;
  end
endmodule

// File: rtl/tbase_reload_timer.sv
module tbase_reload_timer
  import tbase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              haltMode,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] reloadQ;
  logic              ovfPulse;
  logic              ieQ;
  logic              flagQ;

  tbase_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .haltMode(haltMode),
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .ieWrBit(wrData[1]),
    .ovfPulse(ovfPulse), .strobe(strobe), .ieQ(ieQ), .flagQ(flagQ),
    .irqReq(irqReq)
  );

  tbase_datapath #(.CNT_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .countVal(countVal), .reloadQ(reloadQ), .ovfPulse(ovfPulse)
  );

  always_comb begin
    unique case (regSel_e'(regSel))
      SEL_STAT:   rdData = {{(DATA_W-2){1'b0}}, ieQ, flagQ};
      SEL_RELOAD: rdData = reloadQ;
      SEL_COUNT:  rdData = countVal;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/tbase_checker.sv
module tbase_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tickEn,
  input logic       haltMode,
  input logic [1:0] regSel,
  input logic       regRd,
  input logic [7:0] rdData,
  input logic       irqReq,
  input logic [7:0] countVal,
  input logic [7:0] reloadQ,
  input logic       ieQ,
  input logic       flagQ
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && !haltMode && countVal != 8'hFF) |=> countVal == 8'($past(countVal) + 8'd1));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tickEn |=> $stable(countVal));
  // R3
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    haltMode |=> $stable(countVal));
  // R4
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && !haltMode && countVal == 8'hFF) |=> (countVal == $past(reloadQ)) && flagQ);
  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regRd && regSel == 2'd0 && !(tickEn && !haltMode && countVal == 8'hFF)) |=> !flagQ);
  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regSel == 2'd0) |-> (rdData[7:2] == 6'd0));
  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ieQ && flagQ) |=> irqReq);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ieQ && flagQ) |=> !irqReq);
endmodule

bind tbase_reload_timer tbase_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .haltMode(haltMode),
  .regSel(regSel), .regRd(regRd), .rdData(rdData), .irqReq(irqReq),
  .countVal(countVal), .reloadQ(reloadQ), .ieQ(ieQ), .flagQ(flagQ)
);

// File: tb/tbase_reload_timer_tb.sv
module tbase_reload_timer_tb;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic       haltMode = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irqReq;

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tbase_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .haltMode(haltMode),
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .wrData(wrData),
    .rdData(rdData), .irqReq(irqReq)
  );

  // monitor: compare each read against the scoreboard
  always @(negedge clk) begin
    if (regRd && expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      compared++;
      if (rdData !== it.exp) begin
        mismatched++;
        $display("FAIL %s: rdData=%02h expected=%02h", it.tag, rdData, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic tick(int n);
    tickEn = 1'b1;
    repeat (n) cyc();
    tickEn = 1'b0;
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    regSel = sel; wrData = d; regWr = 1'b1;
    cyc();
    regWr = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, logic [7:0] exp, string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    regSel = sel; regRd = 1'b1;
    cyc();
    regRd = 1'b0;
  endtask

  task automatic chkIrq(logic exp, string tag);
    compared++;
    if (irqReq !== exp) begin
      mismatched++;
      $display("FAIL %s: irqReq=%0b expected=%0b", tag, irqReq, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    // R1 reset state
    rd(2'd0, 8'h00, "R1 status");
    rd(2'd1, 8'h00, "R1 reload");
    rd(2'd2, 8'h00, "R1 count");
    chkIrq(1'b0, "R1 irq");
    rd(2'd3, 8'h00, "R10 unused addr");
    // R5 reload write does not touch count
    wr(2'd1, 8'hF0);
    rd(2'd1, 8'hF0, "R5 reload readback");
    rd(2'd2, 8'h00, "R5 count untouched");
    // R2 counting and idle hold
    tick(10);
    rd(2'd2, 8'h0A, "R2 count after ticks");
    repeat (3) cyc();
    rd(2'd2, 8'h0A, "R2 idle hold");
    // R10 count is read-only
    wr(2'd2, 8'h55);
    rd(2'd2, 8'h0A, "R10 count write ignored");
    // R3 halt
    haltMode = 1'b1; tick(5); haltMode = 1'b0;
    rd(2'd2, 8'h0A, "R3 halt freeze");
    // R4 reach top without event, then wrap
    tick(245);
    rd(2'd2, 8'hFF, "R2 count at top");
    rd(2'd0, 8'h00, "R4 no early flag");
    tick(1);
    rd(2'd2, 8'hF0, "R4 reload on wrap");
    rd(2'd0, 8'h01, "R4 flag set");
    rd(2'd0, 8'h00, "R6 flag cleared by read");
    // R6/R8 write of flag bit ignored, enable set
    wr(2'd0, 8'h03);
    rd(2'd0, 8'h02, "R6 flag write ignored");
    chkIrq(1'b0, "R9 irq needs flag");
    // R9 irq rises
    tick(16);
    cyc(); cyc();
    chkIrq(1'b1, "R9 irq asserted");
    // R5 reload change mid-period
    wr(2'd1, 8'h20);
    rd(2'd2, 8'hF0, "R5 count kept on reload write");
    rd(2'd0, 8'h03, "R6 status with flag");
    cyc();
    chkIrq(1'b0, "R9 irq drops after clear");
    // R7 collision of wrap and status read
    tick(15);
    tickEn = 1'b1;
    rd(2'd0, 8'h02, "R7 read returns old flag");
    tickEn = 1'b0;
    rd(2'd0, 8'h03, "R7 flag survives");
    rd(2'd2, 8'h20, "R5 new reload used");
    // R8 reserved bits
    wr(2'd0, 8'hFC);
    rd(2'd0, 8'h00, "R8 reserved ignored, enable cleared");
    // R4 reload 0xFF wraps every tick
    wr(2'd1, 8'hFF);
    tick(223);
    rd(2'd2, 8'hFF, "R4 top before wrap");
    tick(1);
    rd(2'd0, 8'h01, "R4 wrap at reload FF");
    tick(1);
    rd(2'd2, 8'hFF, "R4 count stays FF");
    rd(2'd0, 8'h01, "R4 flag every tick");
    // R3 no event under halt
    haltMode = 1'b1; tick(3); haltMode = 1'b0;
    rd(2'd0, 8'h00, "R3 no flag under halt");
    cyc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule